// File: doc/BRIEF.md
# Power-up Serial EEPROM Identifier Loader

This block fetches a 32-bit identifier from an external serial EEPROM that uses a four-wire protocol: chip select, serial clock, command data into the EEPROM and read data out of it. The sequence begins as soon as reset is released. No host command is needed, and the block issues nothing except reads. It sends two read commands, to word address 0 and word address 1. Each command is a start bit, the opcode `10` and a six-bit address. It skips the single zero bit that the EEPROM returns before each word, and it collects the 16 data bits that follow.

The 32 bits land in two 16-bit outputs. The first bit received goes to bit 0 of `id_word0` and the last bit received goes to bit 15 of `id_word1`. Both outputs read zero until the whole identifier is in. They are published together with `load_done` in a single clock cycle. After that, chip select stays low for good, while the serial clock keeps toggling. The serial clock is a free-running divide of `clk`, with each half period lasting `HALF_DIV` cycles. Command bits and chip select change only on the falling edges of the serial clock. Read data is sampled on the rising edges.

The sequencer moves through these states:

| State | Action and exit |
|---|---|
| `ST_RESET_WAIT` | Waits for the first falling edge, then goes to `ST_COMMAND`. |
| `ST_COMMAND` | Shifts out the command bits, then goes to `ST_DUMMY`. |
| `ST_DUMMY` | Discards one rising-edge sample, then goes to `ST_DATA`. |
| `ST_DATA` | Takes 16 rising-edge samples, then goes to `ST_RELEASE`. |
| `ST_RELEASE` | Drops chip select on a falling edge. It goes to `ST_GAP` after the first word, or publishes and goes to `ST_DONE` after the second. |
| `ST_GAP` | Keeps chip select low for one full serial period, then goes to `ST_COMMAND` for the next word. |
| `ST_DONE` | Terminal state. |

Top module: `eeprom_id_loader`

## Requirements
- R1: While reset is low and on the first cycle after its release, `ee_cs`, `ee_di` and `load_done` are 0, and both ID words are 0.
- R2: With `HALF_DIV`=2, `load_done` is still 0 after the 215th rising clock edge following reset release and is 1 after the 216th. In general it rises on edge 108·`HALF_DIV`.
- R3: Exactly two commands are sent. Each is a start bit 1, then opcode bits 1,0, then a six-bit word address sent MSB first. The first command carries address 0 and the second carries address 1.
- R4: No command ever carries an opcode other than `10`, so the block never writes or erases.
- R5: The bit the EEPROM drives right after the last address bit is ignored, whatever its value.
- R6: The i-th data bit received (i = 0..31) appears at bit i of the identifier. Bits 0–15 are `id_word0` and bits 16–31 are `id_word1`.
- R7: Both ID words read 0 while `load_done` is 0. Once set, `load_done` stays set until reset.
- R8: Chip select is low for at least one full serial clock period between the two commands, and it stays low after `load_done`.
- R9: `ee_sk` toggles every `HALF_DIV` clock cycles from reset release onward, including after completion. Any 40-cycle window therefore holds exactly 10 rising edges when `HALF_DIV`=2.
- R10: `ee_cs` and `ee_di` change only on clock edges where `ee_sk` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the load restarts on release |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | Free-running serial clock to the EEPROM |
| ee_di | output | 1 | Command data shifted into the EEPROM |
| ee_do | input | 1 | Read data shifted out of the EEPROM |
| id_word0 | output | WORD_W | Identifier bits 0..15 (first 16 bits received) |
| id_word1 | output | WORD_W | Identifier bits 16..31 (last 16 bits received) |
| load_done | output | 1 | High once both words are loaded |

## Verification
The only stimulus is the release of reset. The identifier and `load_done` are due on exactly clock edge 216 after that release, so the bench counts rising edges from the release and samples on the falling edge that follows edges 215 and 216. A behavioural EEPROM model reacts to the rising edges of `ee_sk`. It records each command as its ninth bit arrives, and it puts a chosen value on the dummy slot, which may be 0 or 1. Every command and gap check is therefore read from the model's record once `load_done` is due. The edge-alignment and clock-continuity checks compare samples taken on successive falling edges of `clk`, which places each output change on the cycle it occurred.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

    // Sequencer states of the identifier loader
    typedef enum logic [2:0] {
        ST_RESET_WAIT = 3'd0,
        ST_COMMAND    = 3'd1,
        ST_DUMMY      = 3'd2,
        ST_DATA       = 3'd3,
        ST_RELEASE    = 3'd4,
        ST_GAP        = 3'd5,
        ST_DONE       = 3'd6
    } ld_state_e;

    // Fixed command framing: leading marker bit and two-bit read code
    localparam logic       CMD_START_BIT = 1'b1;
    localparam logic [1:0] CMD_READ_CODE = 2'b10;
    localparam int         CMD_HDR_W     = 3;

endpackage

// File: rtl/eeld_sk_gen.sv
module eeld_sk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic term;

    generate
        if (HALF_DIV == 1) begin : g_every_cycle
            assign term = 1'b1;
        end else begin : g_divided
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (term) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign term = (cnt == CNT_W'(HALF_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk <= 1'b0;
        end else if (term) begin
            sk <= ~sk;
        end
    end

    // Tick asserted in the cycle whose closing edge moves sk
    assign rise_tick = term & ~sk;
    assign fall_tick = term &  sk;

endmodule

// File: rtl/eeld_cmd_serializer.sv
module eeld_cmd_serializer
    import eeld_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              cmd_bit
);
    localparam int CMD_W = CMD_HDR_W + ADDR_W;

    logic [CMD_W-1:0] cmd_word;

    assign cmd_word = {CMD_START_BIT, CMD_READ_CODE, word_addr};

    // Index 0 selects the most significant (first transmitted) bit
    always_comb begin
        cmd_bit = 1'b0;
        for (int i = 0; i < CMD_W; i++) begin
            if (bit_idx == IDX_W'(i)) begin
                cmd_bit = cmd_word[CMD_W-1-i];
            end
        end
    end

endmodule

// File: rtl/eeld_id_assembler.sv
module eeld_id_assembler #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            shift_en,
    input  logic                            bit_in,
    input  logic                            publish,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] id_words
);
    localparam int TOTAL_W = WORD_W * NUM_WORDS;

    logic [TOTAL_W-1:0] collect_q;

    // Right shift: the earliest sample ends in bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collect_q <= '0;
        end else if (shift_en) begin
            collect_q <= {bit_in, collect_q[TOTAL_W-1:1]};
        end
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    id_words[w] <= '0;
                end else if (publish) begin
                    id_words[w] <= collect_q[w*WORD_W +: WORD_W];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader
    import eeld_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int ADDR_W    = 6,
    parameter int WORD_W    = 16,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic [WORD_W-1:0] id_word0,
    output logic [WORD_W-1:0] id_word1,
    output logic              load_done
);
    localparam int NUM_WORDS = 2;
    localparam int CMD_W     = CMD_HDR_W + ADDR_W;
    localparam int MAX_CNT   = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int BIT_W     = $clog2(MAX_CNT + 1);
    localparam int WIDX_W    = $clog2(NUM_WORDS);

    ld_state_e           state_q, state_n;
    logic [BIT_W-1:0]    bit_cnt_q, bit_cnt_n;
    logic [WIDX_W-1:0]   word_idx_q, word_idx_n;

    logic                sk_rise, sk_fall;
    logic                cmd_bit;
    logic [BIT_W-1:0]    ser_idx;
    logic [ADDR_W-1:0]   word_addr;
    logic                shift_en, publish, last_word;
    logic [NUM_WORDS-1:0][WORD_W-1:0] id_words;

    // Serial clock and its edge ticks
    eeld_sk_gen #(.HALF_DIV(HALF_DIV)) sk_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sk        (ee_sk),
        .rise_tick (sk_rise),
        .fall_tick (sk_fall)
    );

    // Command bit selection
    assign word_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(word_idx_q);
    assign ser_idx   = (state_q == ST_COMMAND) ? bit_cnt_q : '0;

    eeld_cmd_serializer #(.ADDR_W(ADDR_W), .IDX_W(BIT_W)) ser_i (
        .word_addr (word_addr),
        .bit_idx   (ser_idx),
        .cmd_bit   (cmd_bit)
    );

    // Identifier collection
    assign last_word = (word_idx_q == WIDX_W'(NUM_WORDS - 1));
    assign shift_en  = (state_q == ST_DATA) && sk_rise;
    assign publish   = (state_q == ST_RELEASE) && sk_fall && last_word;

    eeld_id_assembler #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) asm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (ee_do),
        .publish  (publish),
        .id_words (id_words)
    );

    assign id_word0 = id_words[0];
    assign id_word1 = id_words[1];

    // Next-state and counter logic
    always_comb begin
        state_n    = state_q;
        bit_cnt_n  = bit_cnt_q;
        word_idx_n = word_idx_q;
        unique case (state_q)
            ST_RESET_WAIT, ST_GAP: begin
                if (sk_fall) begin
                    state_n   = ST_COMMAND;
                    bit_cnt_n = BIT_W'(1);
                end
            end
            ST_COMMAND: begin
                if (sk_fall) begin
                    if (bit_cnt_q == BIT_W'(CMD_W)) begin
                        state_n = ST_DUMMY;
                    end else begin
                        bit_cnt_n = bit_cnt_q + 1'b1;
                    end
                end
            end
            ST_DUMMY: begin
                if (sk_rise) begin
                    state_n   = ST_DATA;
                    bit_cnt_n = '0;
                end
            end
            ST_DATA: begin
                if (sk_rise) begin
                    if (bit_cnt_q == BIT_W'(WORD_W - 1)) begin
                        state_n = ST_RELEASE;
                    end else begin
                        bit_cnt_n = bit_cnt_q + 1'b1;
                    end
                end
            end
            ST_RELEASE: begin
                if (sk_fall) begin
                    if (last_word) begin
                        state_n = ST_DONE;
                    end else begin
                        state_n    = ST_GAP;
                        word_idx_n = word_idx_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_n = ST_DONE;
            end
            default: begin
                state_n = ST_RESET_WAIT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RESET_WAIT;
            bit_cnt_q  <= '0;
            word_idx_q <= '0;
        end else begin
            state_q    <= state_n;
            bit_cnt_q  <= bit_cnt_n;
            word_idx_q <= word_idx_n;
        end
    end

    // Registered pin outputs, updated only on falling serial edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_cs     <= 1'b0;
            ee_di     <= 1'b0;
            load_done <= 1'b0;
        end else if (sk_fall) begin
            unique case (state_q)
                ST_RESET_WAIT, ST_GAP: begin
                    ee_cs <= 1'b1;
                    ee_di <= cmd_bit;
                end
                ST_COMMAND: begin
                    if (bit_cnt_q == BIT_W'(CMD_W)) begin
                        ee_di <= 1'b0;
                    end else begin
                        ee_di <= cmd_bit;
                    end
                end
                ST_RELEASE: begin
                    ee_cs <= 1'b0;
                    ee_di <= 1'b0;
                    if (last_word) begin
                        load_done <= 1'b1;
                    end
                end
                ST_DUMMY, ST_DATA, ST_DONE: begin
                    ee_di <= 1'b0;
                end
                default: begin
                    ee_cs <= 1'b0;
                    ee_di <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/eeld_checker.sv
module eeld_checker #(
    parameter int HALF_DIV = 2,
    parameter int WORD_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di,
    input logic [WORD_W-1:0] id_word0,
    input logic [WORD_W-1:0] id_word1,
    input logic              load_done
);
    localparam int HOLD_W = $clog2(HALF_DIV + 2) + 1;

    logic              sk_seen;
    logic [HOLD_W-1:0] sk_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_seen <= 1'b0;
            sk_hold <= '0;
        end else begin
            sk_seen <= ee_sk;
            if (ee_sk != sk_seen) begin
                sk_hold <= '0;
            end else if (sk_hold != '1) begin
                sk_hold <= sk_hold + 1'b1;
            end
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!ee_cs && !ee_di && !load_done && id_word0 == '0 && id_word1 == '0));

    assert_ids_zero_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (id_word0 == '0 && id_word1 == '0));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    assert_cs_low_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !ee_cs);

    assert_sk_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sk_hold <= HOLD_W'(HALF_DIV));

    assert_cs_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_cs) |-> $fell(ee_sk));

    assert_di_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_di) |-> $fell(ee_sk));

endmodule

bind eeprom_id_loader eeld_checker #(.HALF_DIV(HALF_DIV), .WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .id_word0  (id_word0),
    .id_word1  (id_word1),
    .load_done (load_done)
);

// File: tb/eeprom_id_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_id_loader_tb_top;
    localparam int HALF     = 2;
    localparam int DONE_EDG = 108 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;
    logic [15:0] id_word0, id_word1;
    logic        load_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    eeprom_id_loader #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .id_word0(id_word0), .id_word1(id_word1), .load_done(load_done)
    );

    // Behavioural EEPROM
    logic [15:0] mem [2];
    logic        dummy_val;
    int          m_cnt, m_cmds, m_gap;
    logic [8:0]  m_sr;
    logic [8:0]  m_rec [4];

    always @(posedge ee_sk) begin
        if (!ee_cs) begin
            m_cnt = 0;
            if (m_cmds == 1) m_gap++;
        end else if (m_cnt < 9) begin
            m_sr = {m_sr[7:0], ee_di};
            m_cnt++;
            if (m_cnt == 9) begin
                if (m_cmds < 4) m_rec[m_cmds] = m_sr;
                m_cmds++;
                ee_do <= dummy_val;
            end
        end else if (m_cnt < 25) begin
            ee_do <= mem[m_sr[0]][24 - m_cnt];
            m_cnt++;
        end
    end

    // Edge-alignment monitor (R10)
    logic p_cs, p_di, p_sk, p_rst;
    int   viol;
    always @(negedge clk) begin
        if (rst_n && p_rst && (ee_cs !== p_cs || ee_di !== p_di) && !(p_sk && !ee_sk))
            viol++;
        p_cs = ee_cs; p_di = ee_di; p_sk = ee_sk; p_rst = rst_n;
    end

    function automatic logic [15:0] rev16(input logic [15:0] v);
        for (int i = 0; i < 16; i++) rev16[i] = v[15 - i];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        m_cnt = 0; m_cmds = 0; m_gap = 0; m_sr = '0; viol = 0;
        for (int i = 0; i < 4; i++) m_rec[i] = '0;
    endtask

    task automatic run_trial(input logic [15:0] w0, input logic [15:0] w1,
                             input logic dv, input bit abort);
        int rises;
        bit cs_seen;
        logic last_sk;
        mem[0] = w0; mem[1] = w1; dummy_val = dv;
        @(negedge clk) rst_n = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_di && !load_done && id_word0 == 0 && id_word1 == 0,
              "R1 reset state", {ee_cs, ee_di, load_done, id_word0, id_word1}, 0);
        rst_n = 1'b1;
        if (abort) begin
            repeat (60) @(posedge clk);
            @(negedge clk) rst_n = 1'b0;
            @(negedge clk);
            check(!ee_cs && !load_done && id_word0 == 0 && id_word1 == 0,
                  "R1 mid-load reset", {ee_cs, load_done, id_word0, id_word1}, 0);
            clear_model();
            @(negedge clk) rst_n = 1'b1;
        end
        repeat (DONE_EDG - 1) @(posedge clk);
        @(negedge clk);
        check(!load_done, "R2 done not early", load_done, 0);
        check(id_word0 == 0 && id_word1 == 0, "R7 ids zero before done",
              {id_word0, id_word1}, 0);
        @(posedge clk);
        @(negedge clk);
        check(load_done, "R2 done on time", load_done, 1);
        check(id_word0 == rev16(w0) && id_word1 == rev16(w1),
              dv ? "R6 R5 bit order with dummy=1" : "R6 bit order",
              {id_word1, id_word0}, {rev16(w1), rev16(w0)});
        check(m_cmds == 2, "R3 command count", m_cmds, 2);
        check(m_rec[0] == 9'b1_10_000000 && m_rec[1] == 9'b1_10_000001,
              "R3 command frames", {m_rec[0], m_rec[1]}, {9'b1_10_000000, 9'b1_10_000001});
        check(m_rec[0][7:6] == 2'b10 && m_rec[1][7:6] == 2'b10, "R4 read opcode only",
              {m_rec[0][7:6], m_rec[1][7:6]}, 4'b1010);
        check(m_gap >= 1, "R8 cs gap between reads", m_gap, 1);
        rises = 0; cs_seen = 1'b0; last_sk = ee_sk;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (ee_sk && !last_sk) rises++;
            if (ee_cs) cs_seen = 1'b1;
            last_sk = ee_sk;
        end
        check(rises == 10, "R9 sk continuous", rises, 10);
        check(!cs_seen, "R8 cs low after done", cs_seen, 0);
        check(m_cmds == 2, "R4 no further commands", m_cmds, 2);
        check(viol == 0, "R10 pins change on sk fall", viol, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        run_trial(16'h0000, 16'h0000, 1'b0, 1'b0);
        run_trial(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        run_trial(16'h0001, 16'h8000, 1'b1, 1'b0);
        run_trial(16'hA5C3, 16'h3C5A, 1'b0, 1'b1);
        for (int t = 0; t < 5; t++) begin
            run_trial(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom % 2));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule